// File: doc/BRIEF.md
# Compare-Match Watchdog Timer

This block is a watchdog counter driven by ticks from an external interval timer. A 7-bit binary counter advances by one on each tick. When the count equals a compare value written by software, a watchdog event occurs. Software keeps the system alive by writing a clear request before each event. The clear request and the compare value share one 8-bit write-only control register. Bit 7 is the clear request and bits 6..0 are the compare value.

A separate mode bit selects what the event does. With the mode bit at 1, the event drives an active-low reset output low for a fixed number of clock cycles. The same pulse also puts the block's own registers back to their reset values. With the mode bit at 0, the block works as a plain periodic interval timer. The event sets a sticky interrupt flag, and the counter restarts from zero. A stop input freezes the count without losing it.

Top module: `wdog_cmp_timer`

## Requirements
- R1: After the synchronous reset, `wdt_rst_n_o` is 1, `irq_flag_o` is 0, the compare value is 127 and the mode bit is 0. The first interrupt therefore follows exactly 128 ticks.
- R2: The counter advances by one per `tick_i`, starting from zero. An event occurs on the tick that finds the count equal to the compare value, so it takes compare+1 ticks from zero.
- R3: In interrupt mode (mode bit 0), an event sets `irq_flag_o` in the cycle after the matching tick edge and returns the counter to zero. Events therefore repeat every compare+1 ticks.
- R4: `irq_flag_o` stays at 1 until `irq_clr_i` is high at a clock edge. If a new event arrives in the same cycle as `irq_clr_i`, the flag stays at 1.
- R5: A write with bit 7 = 1 returns the counter to zero at the clock edge after the write. The clear request then drops by itself and counting resumes with the next tick.
- R6: When a pending clear request meets a matching tick in the same cycle, no event occurs and the counter goes to zero.
- R7: In reset mode (mode bit 1), an event drives `wdt_rst_n_o` low for exactly 4 consecutive clock cycles and leaves `irq_flag_o` unchanged.
- R8: The reset pulse restores the compare value to 127, the mode bit to 0 and the counter to 0. Writes are ignored while the pulse is active.
- R9: While `stop_i` is 1, ticks are ignored and the count is held. When `stop_i` returns to 0, counting continues from the held value.
- R10: Without a tick, no event occurs.
- R11: A write with bit 7 = 0 updates the compare value in one cycle and does not disturb the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle tick from the interval timer |
| stop_i | input | 1 | Stop mode: freezes the counter |
| wr_en_i | input | 1 | Write strobe for the control register |
| wr_data_i | input | 8 | Bit 7: clear request; bits 6..0: compare value |
| mode_wr_en_i | input | 1 | Write strobe for the mode bit |
| mode_bit_i | input | 1 | 1: reset on event; 0: interrupt on event |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| irq_flag_o | output | 1 | Sticky interrupt flag |
| wdt_rst_n_o | output | 1 | Active-low reset pulse output |

## Verification
The counting path is tried with several compare values: the reset value 127, small values such as 2, 3 and 5, and zero, where every tick matches. Counting the ticks right up to the event separates an off-by-one period from a correct compare+1 period. Three patterns insert a tick pattern between clear and match: a clear request landing on the matching tick, a compare rewrite without clear, and stop phases holding ticks. Each of these patterns gives a different event tick if the clear priority, the clear-free update or the hold is wrong. The reset-mode case measures the pulse width and then replays 128 ticks to show that the registers fell back to their reset values.

// File: rtl/wdog_pkg.sv
// Package: shared defaults and the event-mode type for the watchdog.
// Assumes: nothing; pure declarations.
package wdog_pkg;
    localparam int CNT_W_DEF     = 7;
    localparam int RST_PULSE_DEF = 4;

    typedef enum logic {
        MODE_IRQ   = 1'b0,
        MODE_RESET = 1'b1
    } wdog_mode_e;
endpackage

// File: rtl/wdog_ctrl_reg.sv
// Control state: compare value, self-clearing clear request, event mode.
// Assumes: srst_i is the block's internal reset pulse; writes during it are dropped.
module wdog_ctrl_reg
    import wdog_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srst_i,
    input  logic             wr_en_i,
    input  logic [CNT_W:0]   wr_data_i,
    input  logic             mode_wr_en_i,
    input  logic             mode_bit_i,
    output logic [CNT_W-1:0] cmp_o,
    output logic             clr_req_o,
    output wdog_mode_e       mode_o
);
    // Register writes; the clear request lives for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_i) begin
            cmp_o     <= '1;
            clr_req_o <= 1'b0;
            mode_o    <= MODE_IRQ;
        end else begin
            clr_req_o <= 1'b0;
            if (wr_en_i) begin
                cmp_o     <= wr_data_i[CNT_W-1:0];
                clr_req_o <= wr_data_i[CNT_W];
            end
            if (mode_wr_en_i) begin
                mode_o <= wdog_mode_e'(mode_bit_i);
            end
        end
    end
endmodule

// File: rtl/wdog_counter.sv
// Binary tick counter with compare; flags a match and restarts from zero.
// Assumes: tick_i is a single-cycle strobe; clear request outranks a match.
module wdog_counter #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srst_i,
    input  logic             tick_i,
    input  logic             stop_i,
    input  logic             clr_req_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic             match_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             adv;

    // A tick counts only outside stop mode and with no clear pending.
    always_comb begin
        adv     = tick_i && !stop_i && !clr_req_i && !srst_i;
        match_o = adv && (cnt_q == cmp_i);
    end

    // Counter update: reset, clear, wrap-on-match, else increment.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_i) begin
            cnt_q <= '0;
        end else if (clr_req_i) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= match_o ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdog_event.sv
// Turns a match into a sticky interrupt flag or a fixed-width reset pulse.
// Assumes: match_i is one cycle wide; srst_o feeds back as internal reset.
module wdog_event
    import wdog_pkg::*;
#(
    parameter int PULSE_CYC = RST_PULSE_DEF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       match_i,
    input  wdog_mode_e mode_i,
    input  logic       irq_clr_i,
    output logic       irq_flag_o,
    output logic       srst_o,
    output logic       wdt_rst_n_o
);
    localparam int PW = $clog2(PULSE_CYC + 1);

    logic [PW-1:0] pulse_q;

    // Interrupt flag: a new event wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_flag_o <= 1'b0;
        end else if (match_i && mode_i == MODE_IRQ) begin
            irq_flag_o <= 1'b1;
        end else if (irq_clr_i) begin
            irq_flag_o <= 1'b0;
        end
    end

    // Reset pulse down-counter, loaded on a reset-mode event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= '0;
        end else if (match_i && mode_i == MODE_RESET) begin
            pulse_q <= PW'(PULSE_CYC);
        end else if (pulse_q != '0) begin
            pulse_q <= pulse_q - 1'b1;
        end
    end

    // Pulse drives both the pin and the internal register reset.
    always_comb begin
        srst_o      = (pulse_q != '0);
        wdt_rst_n_o = !srst_o;
    end
endmodule

// File: rtl/wdog_cmp_timer.sv
// Top: watchdog / interval timer with compare register and stop hold.
// Assumes: tick_i comes from an interval timer in the same clock domain.
module wdog_cmp_timer
    import wdog_pkg::*;
#(
    parameter int CNT_W     = CNT_W_DEF,
    parameter int PULSE_CYC = RST_PULSE_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_i,
    input  logic           stop_i,
    input  logic           wr_en_i,
    input  logic [CNT_W:0] wr_data_i,
    input  logic           mode_wr_en_i,
    input  logic           mode_bit_i,
    input  logic           irq_clr_i,
    output logic           irq_flag_o,
    output logic           wdt_rst_n_o
);
    logic [CNT_W-1:0] cmp;
    logic             clr_req;
    wdog_mode_e       mode;
    logic             match;
    logic             srst;

    wdog_ctrl_reg #(.CNT_W(CNT_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .srst_i       (srst),
        .wr_en_i      (wr_en_i),
        .wr_data_i    (wr_data_i),
        .mode_wr_en_i (mode_wr_en_i),
        .mode_bit_i   (mode_bit_i),
        .cmp_o        (cmp),
        .clr_req_o    (clr_req),
        .mode_o       (mode)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .srst_i    (srst),
        .tick_i    (tick_i),
        .stop_i    (stop_i),
        .clr_req_i (clr_req),
        .cmp_i     (cmp),
        .match_o   (match)
    );

    wdog_event #(.PULSE_CYC(PULSE_CYC)) u_evt (
        .clk         (clk),
        .rst_n       (rst_n),
        .match_i     (match),
        .mode_i      (mode),
        .irq_clr_i   (irq_clr_i),
        .irq_flag_o  (irq_flag_o),
        .srst_o      (srst),
        .wdt_rst_n_o (wdt_rst_n_o)
    );
endmodule

// File: rtl/wdog_cmp_timer_chk.sv
// Checker: temporal properties of the watchdog outputs, bound to the top.
// Assumes: synchronous active-low reset on rst_n.
module wdog_cmp_timer_chk #(
    parameter int PULSE_CYC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic tick_i,
    input logic stop_i,
    input logic irq_clr_i,
    input logic irq_flag_o,
    input logic wdt_rst_n_o
);
    localparam int LW = $clog2(PULSE_CYC + 1) + 1;

    logic [LW-1:0] low_cnt;

    // Counts consecutive cycles with the reset output low.
    always_ff @(posedge clk) begin
        if (!rst_n || wdt_rst_n_o) low_cnt <= '0;
        else                        low_cnt <= low_cnt + 1'b1;
    end

    AST_PULSE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        !wdt_rst_n_o |-> low_cnt < LW'(PULSE_CYC)); // R7
    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_rst_n_o) |-> low_cnt == LW'(PULSE_CYC)); // R7
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag_o && !irq_clr_i |=> irq_flag_o); // R4
    AST_STOP_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i && !irq_flag_o |=> !irq_flag_o); // R9
    AST_STOP_NO_RST: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i && wdt_rst_n_o |=> wdt_rst_n_o); // R9
    AST_NO_TICK_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i && !irq_flag_o && wdt_rst_n_o |=> !irq_flag_o && wdt_rst_n_o); // R10
endmodule

bind wdog_cmp_timer wdog_cmp_timer_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .stop_i      (stop_i),
    .irq_clr_i   (irq_clr_i),
    .irq_flag_o  (irq_flag_o),
    .wdt_rst_n_o (wdt_rst_n_o)
);

// File: tb/wdog_cmp_timer_test.sv
// Directed bench: one task per scenario, each checking its own results.
module wdog_cmp_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       stop_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = '0;
    logic       mode_wr_en_i = 1'b0;
    logic       mode_bit_i = 1'b0;
    logic       irq_clr_i = 1'b0;
    logic       irq_flag_o;
    logic       wdt_rst_n_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    wdog_cmp_timer uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .stop_i       (stop_i),
        .wr_en_i      (wr_en_i),
        .wr_data_i    (wr_data_i),
        .mode_wr_en_i (mode_wr_en_i),
        .mode_bit_i   (mode_bit_i),
        .irq_clr_i    (irq_clr_i),
        .irq_flag_o   (irq_flag_o),
        .wdt_rst_n_o  (wdt_rst_n_o)
    );

    always #4 clk = ~clk;  // 125 MHz

    task automatic check(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // n single-cycle ticks, one every two clocks; sampled at a negedge.
    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
            @(negedge clk);
        end
    endtask

    // Control register write; returns once a clear request has taken effect.
    task automatic wr_ctrl(input logic clr, input logic [6:0] cmp);
        wr_en_i = 1'b1;
        wr_data_i = {clr, cmp};
        @(negedge clk);
        wr_en_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr_mode(input logic m);
        mode_wr_en_i = 1'b1;
        mode_bit_i = m;
        @(negedge clk);
        mode_wr_en_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic clr_irq();
        irq_clr_i = 1'b1;
        @(negedge clk);
        irq_clr_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        check(wdt_rst_n_o, 1, "R1 reset output idle");
        check(irq_flag_o, 0, "R1 irq after reset");
        ticks(127);
        check(irq_flag_o, 0, "R1 no irq after 127 ticks");
        check(wdt_rst_n_o, 1, "R1 mode is interrupt");
        ticks(1);
        check(irq_flag_o, 1, "R1 irq on tick 128 (compare 127)");
        clr_irq();
    endtask

    task automatic t_periodic();
        wr_ctrl(1'b1, 7'd3);
        ticks(3);
        check(irq_flag_o, 0, "R2 no event before compare+1 ticks");
        ticks(1);
        check(irq_flag_o, 1, "R2 event on tick compare+1");
        clr_irq();
        ticks(3);
        check(irq_flag_o, 0, "R3 counter restarted after event");
        ticks(1);
        check(irq_flag_o, 1, "R3 repeated event after compare+1");
        clr_irq();
    endtask

    task automatic t_irq_sticky();
        wr_ctrl(1'b1, 7'd0);
        ticks(1);
        check(irq_flag_o, 1, "R4 flag set with compare 0");
        repeat (10) @(negedge clk);
        check(irq_flag_o, 1, "R4 flag held without clear");
        tick_i = 1'b1;
        irq_clr_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        irq_clr_i = 1'b0;
        check(irq_flag_o, 1, "R4 new event beats same-cycle clear");
        clr_irq();
        check(irq_flag_o, 0, "R4 flag cleared by irq_clr_i");
    endtask

    task automatic t_no_tick();
        repeat (200) @(negedge clk);
        check(irq_flag_o, 0, "R10 no event without tick (compare 0)");
        check(wdt_rst_n_o, 1, "R10 no reset without tick");
    endtask

    task automatic t_clear();
        wr_ctrl(1'b1, 7'd5);
        ticks(4);
        wr_ctrl(1'b1, 7'd5);
        ticks(5);
        check(irq_flag_o, 0, "R5 clear restarted count");
        ticks(1);
        check(irq_flag_o, 1, "R5 counting resumed after self-clear");
        clr_irq();
    endtask

    task automatic t_clear_vs_match();
        wr_ctrl(1'b1, 7'd3);
        ticks(3);
        wr_en_i = 1'b1;
        wr_data_i = 8'h83;
        @(negedge clk);
        wr_en_i = 1'b0;
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        @(negedge clk);
        check(irq_flag_o, 0, "R6 clear suppresses coinciding match");
        ticks(3);
        check(irq_flag_o, 0, "R6 counter zeroed by clear");
        ticks(1);
        check(irq_flag_o, 1, "R6 next event after compare+1");
        clr_irq();
    endtask

    task automatic t_cmp_update();
        wr_ctrl(1'b1, 7'd10);
        ticks(4);
        wr_ctrl(1'b0, 7'd5);
        ticks(1);
        check(irq_flag_o, 0, "R11 count kept across compare write");
        ticks(1);
        check(irq_flag_o, 1, "R11 new compare used at count 5");
        clr_irq();
    endtask

    task automatic t_stop();
        wr_ctrl(1'b1, 7'd5);
        ticks(3);
        stop_i = 1'b1;
        ticks(10);
        check(irq_flag_o, 0, "R9 no event during stop");
        stop_i = 1'b0;
        ticks(2);
        check(irq_flag_o, 0, "R9 count held, not advanced");
        ticks(1);
        check(irq_flag_o, 1, "R9 count resumed from held value");
        clr_irq();
    endtask

    task automatic t_reset_mode();
        int lows;
        wr_mode(1'b1);
        wr_ctrl(1'b1, 7'd2);
        ticks(2);
        check(wdt_rst_n_o, 1, "R7 no pulse before event");
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        lows = 0;
        for (int i = 0; i < 10; i++) begin
            if (!wdt_rst_n_o) lows++;
            if (i == 0) begin
                wr_en_i = 1'b1;
                wr_data_i = 8'h05;
            end else begin
                wr_en_i = 1'b0;
            end
            @(negedge clk);
        end
        check(lows, 4, "R7 reset pulse width");
        check(irq_flag_o, 0, "R7 no irq in reset mode");
        ticks(127);
        check(irq_flag_o, 0, "R8 compare restored to 127");
        check(wdt_rst_n_o, 1, "R8 mode restored to interrupt");
        ticks(1);
        check(irq_flag_o, 1, "R8 event after 128 ticks from zero");
        clr_irq();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_periodic();
        t_irq_sticky();
        t_no_tick();
        t_clear();
        t_clear_vs_match();
        t_cmp_update();
        t_stop();
        t_reset_mode();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule